// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

The engine paints a rectangle of byte-addressed frame memory with one constant pixel value. A single `start` pulse hands it the rectangle's stored corner, its size, its direction flags, a pitch/base pair, a pixel-format code and an operation code. The operation code picks the colour: the brush colour input, or an opaque black or white built from palette bytes.

The engine captures every input on `start`, so the caller may change them during the fill. In the next cycle it checks the request in one step. If the request is valid, it writes the rectangle row by row, top row first, one byte per clock, through a synchronous write port. When the fill ends it raises `done` for one cycle and presents the updated Y coordinate. A request with an unknown operation or format sets `err`. A request that would leave memory is dropped without any write.

Top module: `rect_fill_engine`

## Requirements
- R1: Operation code 0xF0 fills with `brush_color` unchanged.
- R2: Operation code 0x00 fills with the 32-bit value {0xFF, pal0, pal1, pal2}, bits 31:24 down to 7:0, where pal entry i is `palette[8*i+7:8*i]`.
- R3: Operation code 0xFF fills with {0xFF, pal3, pal4, pal5}, with the same byte layout as R2.
- R4: Format code 2 gives 1 byte per pixel, 3 and 4 give 2, 5 gives 3 and 6 gives 4. Each pixel is the low bytes of the fill value, written least significant byte first at the lowest address.
- R5: Row r (0 first) of the fill writes width×bpp consecutive bytes from base + x0×bpp + (y0+r)×pitch. The engine uses `own_pitch`/`own_base` when `use_own_ptr`=1 and `dflt_pitch`/`dflt_base` otherwise.
- R6: The start corner is x0 = `dst_x` if `left_to_right`, else `dst_x`+1−`width`. Likewise y0 = `dst_y` if `top_to_bottom`, else `dst_y`+1−`height`. Both are taken modulo 2^16.
- R7: After a completed or zero-size fill, `y_result` = y0+`height` when `top_to_bottom`=1, else y0. The X coordinate is not reported.
- R8: The fill is aborted with no writes, `err`=0 and `y_result`=`dst_y` in any of these cases:
  - the pitch is zero;
  - x0 or y0 is above 0x3FFF;
  - the base is at or beyond the memory size;
  - for a non-empty rectangle, base + (y0+height−1)×pitch + (x0+width)×bpp exceeds the memory size.
- R9: An operation code other than those in R1–R3, or a format code other than 2–6, sets `err`=1. Such a request makes no writes and leaves `y_result`=`dst_y`.
- R10: `busy` rises in the cycle after an accepted `start` and falls after the single-cycle `done` pulse. A `start` while `busy` is ignored.
- R11: A width or height of zero gives no writes, `err`=0 and the `y_result` of R7.
- R12: A valid fill makes exactly width×height×bpp single-byte writes on consecutive cycles, and `done` follows the last write in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken when idle |
| op_code | input | 8 | Colour source selection |
| pix_fmt | input | 4 | Pixel format code |
| dst_x | input | 16 | Stored destination X |
| dst_y | input | 16 | Stored destination Y |
| width | input | 16 | Rectangle width in pixels |
| height | input | 16 | Rectangle height in rows |
| left_to_right | input | 1 | X direction flag |
| top_to_bottom | input | 1 | Y direction flag |
| use_own_ptr | input | 1 | Select own pitch/base rather than default |
| own_pitch | input | 16 | Own row pitch in bytes |
| own_base | input | 16 | Own base byte address |
| dflt_pitch | input | 16 | Default row pitch in bytes |
| dflt_base | input | 16 | Default base byte address |
| brush_color | input | 32 | Brush colour value |
| palette | input | 48 | Six palette bytes, entry i at bits 8i+7:8i |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | AW | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported operation or format on last request |
| y_result | output | 16 | Updated Y coordinate after done |

## Verification
The hardest cases sit at the edges of the range check. One is a rectangle whose last byte lands on the final memory address, next to the same rectangle shifted one pixel further. The other is a start corner that wraps below zero when a direction flag is cleared. The bench reaches both by choosing stored coordinates, sizes and pitch arithmetically so that the extent sits exactly at the memory size or one pixel past it. It also reaches them with a cleared direction flag and a stored coordinate smaller than the size. A further case is a second `start` issued while busy, with different parameters, whose effect must be nil on the final memory image.

// File: rtl/fill_pkg.sv
// Package: shared types, operation codes and format decoding for the fill engine.
// Assumes format codes 2..6 are the only supported ones.
package fill_pkg;

    localparam logic [7:0] OP_BRUSH = 8'hF0;
    localparam logic [7:0] OP_BLACK = 8'h00;
    localparam logic [7:0] OP_WHITE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } fill_state_e;

    // Bytes per pixel for a format code; zero marks an unsupported code.
    function automatic logic [2:0] bytes_per_pixel(input logic [3:0] fmt);
        case (fmt)
            4'd2:       return 3'd1;
            4'd3, 4'd4: return 3'd2;
            4'd5:       return 3'd3;
            4'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fill_color_sel.sv
// Colour selector: forms the 32-bit fill value from the operation code.
// Assumes palette entry i occupies bits 8i+7:8i. Pure combinational.
module fill_color_sel
    import fill_pkg::*;
(
    input  logic [7:0]  op_i,
    input  logic [31:0] brush_i,
    input  logic [47:0] pal_i,
    output logic [31:0] color_o,
    output logic        op_ok_o
);

    // Pick the colour source and flag unknown codes.
    always_comb begin
        op_ok_o = 1'b1;
        color_o = '0;
        case (op_i)
            OP_BRUSH: color_o = brush_i;
            OP_BLACK: color_o = {8'hFF, pal_i[7:0],   pal_i[15:8],  pal_i[23:16]};
            OP_WHITE: color_o = {8'hFF, pal_i[31:24], pal_i[39:32], pal_i[47:40]};
            default:  op_ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fill_setup.sv
// Request checker: derives the start corner, start address, row length and
// resulting Y, and decides whether the request must be dropped.
// Assumes its inputs are held stable (captured by the top). Combinational.
module fill_setup
    import fill_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int CW        = 16,
    parameter int COORD_MAX = 16'h3FFF,
    localparam int AW       = $clog2(MEM_BYTES),
    localparam int RBW      = CW + 3,
    localparam int WW       = 2 * CW + 16
)(
    input  logic [CW-1:0]  x_i,
    input  logic [CW-1:0]  y_i,
    input  logic [CW-1:0]  w_i,
    input  logic [CW-1:0]  h_i,
    input  logic           ltr_i,
    input  logic           ttb_i,
    input  logic [CW-1:0]  pitch_i,
    input  logic [CW-1:0]  base_i,
    input  logic [3:0]     fmt_i,
    output logic [2:0]     bpp_o,
    output logic           fmt_ok_o,
    output logic           abort_o,
    output logic           empty_o,
    output logic [AW-1:0]  start_addr_o,
    output logic [RBW-1:0] row_bytes_o,
    output logic [CW-1:0]  next_y_o
);

    logic [CW-1:0] x0, y0;
    logic [WW-1:0] limit;

    // Start corner from the direction flags, wrapping modulo 2^CW.
    always_comb begin
        x0 = ltr_i ? x_i : CW'(x_i + 1'b1 - w_i);
        y0 = ttb_i ? y_i : CW'(y_i + 1'b1 - h_i);
    end

    // Extent, range decision and derived addresses.
    always_comb begin
        bpp_o    = bytes_per_pixel(fmt_i);
        fmt_ok_o = (bpp_o != 3'd0);
        empty_o  = (w_i == '0) || (h_i == '0);
        limit    = WW'(base_i) + (WW'(y0) + WW'(h_i) - WW'(1)) * WW'(pitch_i)
                 + (WW'(x0) + WW'(w_i)) * WW'(bpp_o);
        abort_o  = (pitch_i == '0)
                || (WW'(x0) > WW'(COORD_MAX)) || (WW'(y0) > WW'(COORD_MAX))
                || (WW'(base_i) >= WW'(MEM_BYTES))
                || (!empty_o && (limit > WW'(MEM_BYTES)));
        start_addr_o = AW'(WW'(base_i) + WW'(x0) * WW'(bpp_o) + WW'(y0) * WW'(pitch_i));
        row_bytes_o  = RBW'(RBW'(w_i) * RBW'(bpp_o));
        next_y_o     = ttb_i ? CW'(y0 + h_i) : y0;
    end

endmodule

// File: rtl/fill_walker.sv
// Address walker: emits one byte write per cycle over a rectangle,
// top row first, advancing by the pitch between rows.
// Assumes load arrives only while idle and row_bytes/rows are nonzero.
module fill_walker #(
    parameter int MEM_BYTES = 4096,
    parameter int CW        = 16,
    localparam int AW       = $clog2(MEM_BYTES),
    localparam int RBW      = CW + 3
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [AW-1:0]  start_addr_i,
    input  logic [RBW-1:0] row_bytes_i,
    input  logic [CW-1:0]  rows_i,
    input  logic [CW-1:0]  pitch_i,
    input  logic [2:0]     bpp_i,
    output logic           we_o,
    output logic [AW-1:0]  addr_o,
    output logic [1:0]     lane_o,
    output logic           last_o
);

    logic           active;
    logic [AW-1:0]  row_addr;
    logic [RBW-1:0] off;
    logic [CW-1:0]  row;
    logic           row_end;

    // Outputs of the walk and end-of-row/end-of-fill detection.
    always_comb begin
        row_end = (off == row_bytes_i - 1'b1);
        we_o    = active;
        addr_o  = AW'(row_addr + AW'(off));
        last_o  = active && row_end && (row == rows_i - 1'b1);
    end

    // Counter update: byte lane, offset in row, row index and row address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            row_addr <= '0;
            off      <= '0;
            row      <= '0;
            lane_o   <= '0;
        end else if (load_i) begin
            active   <= 1'b1;
            row_addr <= start_addr_i;
            off      <= '0;
            row      <= '0;
            lane_o   <= '0;
        end else if (active) begin
            if (row_end) begin
                off      <= '0;
                lane_o   <= '0;
                row      <= row + 1'b1;
                row_addr <= AW'(row_addr + AW'(pitch_i));
                if (last_o) active <= 1'b0;
            end else begin
                off    <= off + 1'b1;
                lane_o <= ({1'b0, lane_o} == bpp_i - 3'd1) ? 2'd0 : lane_o + 2'd1;
            end
        end
    end

    // R12: inside a row the byte address steps by one each cycle.
    a_r12_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && off != '0) |-> (addr_o == AW'($past(addr_o) + 1'b1)));

    // R5: a new row starts one pitch after the previous row's start.
    a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && off == '0 && row != '0) |-> (addr_o == AW'($past(row_addr) + AW'(pitch_i))));

endmodule

// File: rtl/rect_fill_engine.sv
// Top: captures a fill request, checks it, walks the rectangle writing the
// selected colour one byte per cycle, then pulses done with the new Y.
// Assumes a single-port byte-wide synchronous memory of MEM_BYTES bytes.
module rect_fill_engine
    import fill_pkg::*;
#(
    parameter int MEM_BYTES = 4096,
    parameter int CW        = 16,
    parameter int COORD_MAX = 16'h3FFF,
    localparam int AW       = $clog2(MEM_BYTES),
    localparam int RBW      = CW + 3
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    op_code,
    input  logic [3:0]    pix_fmt,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          left_to_right,
    input  logic          top_to_bottom,
    input  logic          use_own_ptr,
    input  logic [CW-1:0] own_pitch,
    input  logic [CW-1:0] own_base,
    input  logic [CW-1:0] dflt_pitch,
    input  logic [CW-1:0] dflt_base,
    input  logic [31:0]   brush_color,
    input  logic [47:0]   palette,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [CW-1:0] y_result
);

    fill_state_e   state;
    logic [7:0]    c_op;
    logic [3:0]    c_fmt;
    logic [CW-1:0] c_x, c_y, c_w, c_h, c_pitch, c_base;
    logic          c_ltr, c_ttb;
    logic [31:0]   c_brush;
    logic [47:0]   c_pal;

    logic [31:0]    color;
    logic           op_ok, fmt_ok, abort_req, empty_req, last_wr;
    logic [2:0]     bpp;
    logic [AW-1:0]  start_addr;
    logic [RBW-1:0] row_bytes;
    logic [CW-1:0]  next_y;
    logic [1:0]     lane;
    logic           load;

    fill_color_sel u_color (
        .op_i    (c_op),
        .brush_i (c_brush),
        .pal_i   (c_pal),
        .color_o (color),
        .op_ok_o (op_ok)
    );

    fill_setup #(.MEM_BYTES(MEM_BYTES), .CW(CW), .COORD_MAX(COORD_MAX)) u_setup (
        .x_i          (c_x),
        .y_i          (c_y),
        .w_i          (c_w),
        .h_i          (c_h),
        .ltr_i        (c_ltr),
        .ttb_i        (c_ttb),
        .pitch_i      (c_pitch),
        .base_i       (c_base),
        .fmt_i        (c_fmt),
        .bpp_o        (bpp),
        .fmt_ok_o     (fmt_ok),
        .abort_o      (abort_req),
        .empty_o      (empty_req),
        .start_addr_o (start_addr),
        .row_bytes_o  (row_bytes),
        .next_y_o     (next_y)
    );

    fill_walker #(.MEM_BYTES(MEM_BYTES), .CW(CW)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_addr_i (start_addr),
        .row_bytes_i  (row_bytes),
        .rows_i       (c_h),
        .pitch_i      (c_pitch),
        .bpp_i        (bpp),
        .we_o         (mem_we),
        .addr_o       (mem_addr),
        .lane_o       (lane),
        .last_o       (last_wr)
    );

    // Status outputs, walker launch and byte lane selection.
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        load      = (state == ST_CHECK) && op_ok && fmt_ok && !abort_req && !empty_req;
        mem_wdata = color[8*lane +: 8];
    end

    // Request capture: all inputs are latched on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_op <= '0; c_fmt <= '0; c_x <= '0; c_y <= '0; c_w <= '0; c_h <= '0;
            c_ltr <= 1'b0; c_ttb <= 1'b0; c_pitch <= '0; c_base <= '0;
            c_brush <= '0; c_pal <= '0;
        end else if (state == ST_IDLE && start) begin
            c_op    <= op_code;
            c_fmt   <= pix_fmt;
            c_x     <= dst_x;
            c_y     <= dst_y;
            c_w     <= width;
            c_h     <= height;
            c_ltr   <= left_to_right;
            c_ttb   <= top_to_bottom;
            c_pitch <= use_own_ptr ? own_pitch : dflt_pitch;
            c_base  <= use_own_ptr ? own_base  : dflt_base;
            c_brush <= brush_color;
            c_pal   <= palette;
        end
    end

    // Sequencer: idle, one check cycle, run, one done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            err      <= 1'b0;
            y_result <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_CHECK;
                    err   <= 1'b0;
                end
                ST_CHECK: begin
                    if (!op_ok || !fmt_ok) begin
                        err      <= 1'b1;
                        y_result <= c_y;
                        state    <= ST_DONE;
                    end else if (abort_req) begin
                        y_result <= c_y;
                        state    <= ST_DONE;
                    end else begin
                        y_result <= next_y;
                        state    <= empty_req ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN:  if (last_wr) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: a flagged request never writes memory.
    a_r9_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !err);

    // R10: done lasts a single cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a start while busy does not disturb the captured request.
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(c_op) && $stable(c_x) && $stable(c_y)));

    // R3: the top byte of a white pixel is opaque.
    a_r3_white_alpha: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && c_op == OP_WHITE && lane == 2'd3) |-> (mem_wdata == 8'hFF));

    // R2: the top byte of a black pixel is opaque.
    a_r2_black_alpha: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && c_op == OP_BLACK && lane == 2'd3) |-> (mem_wdata == 8'hFF));

endmodule

// File: tb/rect_fill_engine_tb.sv
// Bench: sweeps formats, operations, directions and sizes, plus range and
// error corners, comparing a byte-level memory image with an arithmetic model.
module rect_fill_engine_tb_top;

    localparam int MEMB = 4096;
    localparam int AW   = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    op_code = '0;
    logic [3:0]    pix_fmt = '0;
    logic [15:0]   dst_x = '0, dst_y = '0, width = '0, height = '0;
    logic          left_to_right = 1'b1, top_to_bottom = 1'b1, use_own_ptr = 1'b0;
    logic [15:0]   own_pitch = 16'd64, own_base = 16'd300;
    logic [15:0]   dflt_pitch = 16'd48, dflt_base = 16'd100;
    logic [31:0]   brush_color = 32'h89ABCDEF;
    logic [47:0]   palette = 48'h665544332211;
    logic          mem_we, busy, done, err;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [15:0]   y_result;

    rect_fill_engine #(.MEM_BYTES(MEMB)) dut_i (.*);

    always #2 clk = ~clk;

    logic [7:0] bmem [MEMB];
    logic [7:0] emem [MEMB];
    int writes = 0;
    int vectors = 0;
    int misses = 0;
    int cycles = 0;

    // Memory model and write counter.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles >= 150000);
        check(1'b0, "watchdog", cycles, 0);
        finish_run();
    end

    task automatic do_fill(input logic [7:0] op, input logic [3:0] fmt,
                           input int x, input int y, input int w, input int h,
                           input bit ltr, input bit ttb, input bit own,
                           input string tag, input bit poke_busy);
        int bpp, pitch, base, x0, y0, lim, exp_wr, exp_y, wait_cnt;
        bit exp_err, ok_all;
        logic [31:0] col;
        // Model: R1-R3 colour, R4 bytes, R6 corner, R8/R9 rejection, R7 Y.
        case (fmt)
            2: bpp = 1;
            3, 4: bpp = 2;
            5: bpp = 3;
            6: bpp = 4;
            default: bpp = 0;
        endcase
        case (op)
            8'hF0: col = brush_color;
            8'h00: col = {8'hFF, palette[7:0], palette[15:8], palette[23:16]};
            8'hFF: col = {8'hFF, palette[31:24], palette[39:32], palette[47:40]};
            default: col = 'x;
        endcase
        exp_err = (bpp == 0) || !(op == 8'hF0 || op == 8'h00 || op == 8'hFF);
        pitch = own ? own_pitch : dflt_pitch;
        base  = own ? own_base : dflt_base;
        x0 = ltr ? x : ((x + 1 - w) & 16'hFFFF);
        y0 = ttb ? y : ((y + 1 - h) & 16'hFFFF);
        lim = base + (y0 + h - 1) * pitch + (x0 + w) * bpp;
        for (int i = 0; i < MEMB; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            emem[i] = 8'(i * 7 + 3);
        end
        exp_wr = 0;
        exp_y  = y;
        if (!exp_err && pitch != 0 && x0 <= 16'h3FFF && y0 <= 16'h3FFF && base < MEMB &&
            (w == 0 || h == 0 || lim <= MEMB)) begin
            exp_y = ttb ? ((y0 + h) & 16'hFFFF) : y0;
            for (int r = 0; r < h; r++)
                for (int p = 0; p < w; p++)
                    for (int b = 0; b < bpp; b++) begin
                        emem[base + (x0 + p) * bpp + (y0 + r) * pitch + b] = col[8*b +: 8];
                        exp_wr++;
                    end
        end
        @(negedge clk);
        op_code = op; pix_fmt = fmt; dst_x = 16'(x); dst_y = 16'(y);
        width = 16'(w); height = 16'(h);
        left_to_right = ltr; top_to_bottom = ttb; use_own_ptr = own;
        writes = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // Scramble inputs after capture; the engine must not see them.
        op_code = 8'h55; dst_x = 16'd9; dst_y = 16'd9; width = 16'd7;
        check(busy == 1'b1, {"R10 busy after start ", tag}, busy, 1);
        wait_cnt = 0;
        while (!done && wait_cnt < 5000) begin
            if (poke_busy && wait_cnt == 2) begin
                start = 1'b1;   // R10: must be ignored
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
            wait_cnt++;
        end
        check(done == 1'b1, {"R10 done reached ", tag}, done, 1);
        check(writes == exp_wr, {"R12 write count ", tag}, writes, exp_wr);
        check(err == exp_err, {"R9 err flag ", tag}, err, exp_err);
        check(y_result == 16'(exp_y), {"R7 y_result ", tag}, y_result, exp_y);
        ok_all = 1'b1;
        for (int i = 0; i < MEMB; i++)
            if (ok_all && bmem[i] !== emem[i]) begin
                ok_all = 1'b0;
                $display("FAIL %s image at %0d actual=%0h expected=%0h", tag, i, bmem[i], emem[i]);
            end
        vectors++;
        if (!ok_all) misses++;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, {"R10 done single cycle ", tag}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && mem_we == 0 && err == 0, "R10 reset state",
              {busy, done, mem_we, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep: R1 R2 R3 R4 R5 R6 R7 R12.
        for (int f = 2; f <= 6; f++)
            for (int o = 0; o < 3; o++)
                for (int d = 0; d < 4; d++)
                    for (int s = 0; s < 3; s++) begin
                        logic [7:0] op;
                        int w, h;
                        op = (o == 0) ? 8'hF0 : (o == 1) ? 8'h00 : 8'hFF;
                        w = (s == 0) ? 1 : (s == 1) ? 3 : 2;
                        h = (s == 0) ? 1 : (s == 1) ? 2 : 3;
                        do_fill(op, 4'(f), 5, 4, w, h, d[0], d[1], s[0] ^ d[0],
                                (o == 0) ? "R1 sweep" : (o == 1) ? "R2 sweep" : "R3 sweep", 1'b0);
                    end

        // R11: zero width and zero height.
        do_fill(8'hF0, 4'd6, 5, 4, 0, 3, 1'b1, 1'b1, 1'b0, "R11 zero width", 1'b0);
        do_fill(8'hF0, 4'd6, 5, 4, 2, 0, 1'b1, 1'b1, 1'b0, "R11 zero height", 1'b0);
        // R8: zero pitch.
        dflt_pitch = 16'd0;
        do_fill(8'hFF, 4'd2, 5, 4, 2, 2, 1'b1, 1'b1, 1'b0, "R8 zero pitch", 1'b0);
        dflt_pitch = 16'd48;
        // R6 R8: corner wraps below zero.
        do_fill(8'hFF, 4'd2, 0, 4, 2, 2, 1'b0, 1'b1, 1'b0, "R8 x wrap", 1'b0);
        do_fill(8'hFF, 4'd2, 4, 0, 2, 2, 1'b1, 1'b0, 1'b0, "R8 y wrap", 1'b0);
        do_fill(8'hFF, 4'd2, 4, 16'h4000, 1, 1, 1'b1, 1'b1, 1'b0, "R8 y above limit", 1'b0);
        // R8: extent exactly at the end, then one pixel past it.
        own_base = 16'd0; own_pitch = 16'd64;
        do_fill(8'h00, 4'd6, 15, 63, 1, 1, 1'b1, 1'b1, 1'b1, "R8 last byte fits", 1'b0);
        do_fill(8'h00, 4'd6, 16, 63, 1, 1, 1'b1, 1'b1, 1'b1, "R8 one past end", 1'b0);
        own_base = 16'd4096;
        do_fill(8'h00, 4'd2, 0, 0, 1, 1, 1'b1, 1'b1, 1'b1, "R8 base beyond memory", 1'b0);
        own_base = 16'd300;
        // R9: unsupported operation and format.
        do_fill(8'h55, 4'd6, 5, 4, 2, 2, 1'b1, 1'b1, 1'b0, "R9 bad op", 1'b0);
        do_fill(8'hF0, 4'd7, 5, 4, 2, 2, 1'b1, 1'b1, 1'b0, "R9 bad format", 1'b0);
        // R10: start while busy is ignored.
        do_fill(8'hF0, 4'd5, 6, 7, 4, 3, 1'b0, 1'b0, 1'b1, "R10 start while busy", 1'b1);

        finish_run();
    end

endmodule